// File: doc/BRIEF.md
# Atomic Read-Modify-Write Bit Engine

This block sits between a processor-side request port and a peripheral register port. A single request that carries an opcode, an access size, a bit position and a field width becomes one indivisible sequence on the peripheral side: the engine reads the register, changes it, writes it back and then answers the requester. The requester sees only the final answer. It never sees an intermediate value. The engine supports mask logic (AND, OR, XOR), bit-field insert, single-bit test-and-clear and test-and-set, and bit-field extract. Each works on byte, halfword and word registers. Set, clear and toggle are done by software through OR with the mask, AND with the inverted mask, and XOR with the mask.

Acceleration happens only for addresses from 0x4000_0000 to 0x4007_FFFF inclusive. Other addresses pass through as plain reads or writes. While an accelerated sequence runs, a `lock` output tells the bus fabric to keep all other masters off the peripheral. The request side uses valid/ready. The requester raises `req_valid`, holds every request field stable, and waits. `req_ready` is high for exactly one cycle, and `rsp_rdata` and `rsp_err` are valid in that cycle. The requester may apply back-pressure only by not issuing a request. The engine never accepts a request early.

Top module: `rmw_engine`

## Requirements
- R1: Only addresses from 0x4000_0000 to 0x4007_FFFF are accelerated. Outside that range, opcodes LOAD and EXTRACT do a plain read that returns the addressed lane data. Every other defined opcode does a plain write of the low size bits of `req_wdata` and returns 0. Shift and width are not checked there.
- R2: Opcode encoding is 0 LOAD, 1 STORE, 2 AND, 3 OR, 4 XOR, 5 INSERT, 6 TCLR, 7 TSET, 8 EXTRACT. Size encoding is 0 byte, 1 halfword, 2 word. For AND/OR/XOR in the window, the new register value is the old value combined with the operand across the access size. The response is the old value, zero-extended.
- R3: INSERT replaces bits [shift+width-1:shift] with the low `width` bits of the operand and returns the old value. It requires width ≥ 1, width ≤ min(size bits, 16), and shift+width ≤ size bits.
- R4: Byte accesses use lane addr[1:0]. Halfword accesses use lanes {addr[1],0} and {addr[1],1}. Word accesses use all four lanes. `per_be` enables only those lanes, and the data sits at lane×8. Bytes outside those lanes are left unchanged.
- R5: TCLR and TSET return the bit at `shift` in bit 0 with all higher bits zero. In the same sequence they clear or set that bit. They require shift < size bits.
- R6: EXTRACT returns `width` bits starting at `shift`, right-justified and zero-filled, and writes nothing back. It requires 1 ≤ width ≤ size bits and shift+width ≤ size bits.
- R7: A request is rejected with `rsp_err`=1, a zero result and no peripheral access if any of these holds:
  - it has an undefined opcode (9–15);
  - it has size code 3;
  - it is an accelerated request that breaks its field limits.
- R8: `req_ready` is a single-cycle pulse, and the response fields are valid in that cycle.
- R9: For accelerated requests, `lock` rises with the read strobe and stays high through the write-back. That is three cycles for modifying opcodes and two for EXTRACT. `lock` stays low for plain and rejected requests.
- R10: LOAD and STORE inside the window are plain accesses, with no lock.
- R11: During reset, `req_ready`, `lock` and `per_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_ready | output | 1 | One-cycle acceptance and response strobe |
| req_addr | input | 32 | Byte address of the register |
| req_size | input | 2 | Access size code |
| req_op | input | 4 | Opcode |
| req_shift | input | 5 | Bit position within the access |
| req_width | input | 6 | Field width |
| req_wdata | input | 32 | Operand, right-aligned |
| rsp_rdata | output | 32 | Result, right-aligned, valid with req_ready |
| rsp_err | output | 1 | Rejection flag, valid with req_ready |
| per_en | output | 1 | Peripheral access strobe |
| per_we | output | 1 | Peripheral write select |
| per_addr | output | 32 | Word-aligned peripheral address |
| per_be | output | 4 | Byte-lane enables |
| per_wdata | output | 32 | Lane-positioned write data |
| per_rdata | input | 32 | Read data, valid in the cycle after a read strobe |
| lock | output | 1 | Keep other masters off the peripheral |

## Verification
The properties assume two things about the inputs:
- Once the requester raises `req_valid`, it keeps it raised, with all fields unchanged, until the `req_ready` pulse.
- The peripheral returns read data in the cycle after the read strobe.

The bench drives requests on the falling edge and holds them until it sees `req_ready`. Its register model answers reads with exactly one cycle of delay. Field sweeps deliberately go past the legal shift and width limits, so rejection is exercised within the stated protocol and never by breaking it.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [3:0] {
    OP_LOAD    = 4'd0,
    OP_STORE   = 4'd1,
    OP_AND     = 4'd2,
    OP_OR      = 4'd3,
    OP_XOR     = 4'd4,
    OP_INSERT  = 4'd5,
    OP_TCLR    = 4'd6,
    OP_TSET    = 4'd7,
    OP_EXTRACT = 4'd8
  } rmw_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } rmw_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_MOD,
    ST_WRITE,
    ST_DONE
  } rmw_state_e;

  typedef struct packed {
    logic accel;
    logic bad;
    logic reads;
    logic writes;
  } rmw_dec_t;

endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
  import rmw_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
  parameter logic [31:0] WIN_LIMIT = 32'h4007_FFFF,
  parameter int          INS_MAX   = 16,
  localparam int         LANES     = DATA_W / 8,
  localparam int         LB_W      = $clog2(LANES),
  localparam int         SH_W      = $clog2(DATA_W),
  localparam int         WD_W      = SH_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  rmw_size_e         size,
  input  logic [3:0]        op,
  input  logic [SH_W-1:0]   shift,
  input  logic [WD_W-1:0]   width,
  output rmw_dec_t          dec,
  output logic [LB_W-1:0]   lane,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] smask
);

  localparam int         CW      = WD_W + 1;
  localparam logic [CW-1:0] INS_CAP = CW'(INS_MAX);

  logic          in_win;
  logic          size_bad;
  logic          known;
  logic          field_bad;
  logic [CW-1:0] sbits;
  logic [CW-1:0] ins_cap;
  logic [CW-1:0] fend;
  logic [CW-1:0] wid_x;
  logic [CW-1:0] sh_x;
  logic [LB_W:0] nbytes;

  assign in_win = (addr >= ADDR_W'(WIN_BASE)) && (addr <= ADDR_W'(WIN_LIMIT));
  assign wid_x  = {1'b0, width};
  assign sh_x   = {2'b00, shift};
  assign fend   = sh_x + wid_x;
  assign known  = (op <= OP_EXTRACT);

  always_comb begin
    size_bad = 1'b0;
    case (size)
      SZ_BYTE: begin
        sbits  = CW'(8);
        nbytes = (LB_W+1)'(1);
        lane   = addr[LB_W-1:0];
        smask  = DATA_W'({8{1'b1}});
      end
      SZ_HALF: begin
        sbits  = CW'(16);
        nbytes = (LB_W+1)'(2);
        lane   = {addr[LB_W-1:1], 1'b0};
        smask  = DATA_W'({16{1'b1}});
      end
      SZ_WORD: begin
        sbits  = CW'(DATA_W);
        nbytes = (LB_W+1)'(LANES);
        lane   = '0;
        smask  = '1;
      end
      default: begin
        sbits    = CW'(DATA_W);
        nbytes   = (LB_W+1)'(LANES);
        lane     = '0;
        smask    = '1;
        size_bad = 1'b1;
      end
    endcase
  end

  assign ins_cap = (sbits < INS_CAP) ? sbits : INS_CAP;

  always_comb begin
    field_bad = 1'b0;
    case (op)
      OP_INSERT:         field_bad = (wid_x == '0) || (wid_x > ins_cap) || (fend > sbits);
      OP_TCLR, OP_TSET:  field_bad = (sh_x >= sbits);
      OP_EXTRACT:        field_bad = (wid_x == '0) || (wid_x > sbits) || (fend > sbits);
      default:           field_bad = 1'b0;
    endcase
  end

  always_comb begin
    dec.accel = in_win && known && (op != OP_LOAD) && (op != OP_STORE);
    if (!dec.accel) begin
      dec.reads  = (op == OP_LOAD) || (op == OP_EXTRACT);
      dec.writes = !dec.reads;
    end else begin
      dec.reads  = 1'b1;
      dec.writes = (op != OP_EXTRACT);
    end
    dec.bad = size_bad || !known || (dec.accel && field_bad);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = ((LB_W+1)'(g) >= {1'b0, lane}) &&
                   ((LB_W+1)'(g) <  ({1'b0, lane} + nbytes));
  end

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int  DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LB_W   = $clog2(LANES),
  localparam int SH_W   = $clog2(DATA_W),
  localparam int WD_W   = SH_W + 1
) (
  input  logic [3:0]        op,
  input  logic              accel,
  input  logic [LB_W-1:0]   lane,
  input  logic [SH_W-1:0]   shift,
  input  logic [WD_W-1:0]   width,
  input  logic [DATA_W-1:0] smask,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] result
);

  logic [LB_W+2:0]   lane_sh;
  logic [DATA_W-1:0] old_v;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] fmask;
  logic [DATA_W-1:0] bmask;
  logic [DATA_W-1:0] new_v;

  assign lane_sh = {lane, 3'b000};
  assign old_v   = (rdata >> lane_sh) & smask;
  assign opnd    = operand & smask;
  assign wmask   = (width >= WD_W'(DATA_W)) ? '1
                 : ((DATA_W'(1) << width) - DATA_W'(1));
  assign fmask   = wmask << shift;
  assign bmask   = DATA_W'(1) << shift;

  always_comb begin
    new_v  = old_v;
    result = old_v;
    if (!accel) begin
      new_v = opnd;
    end else begin
      case (op)
        OP_AND:     new_v = old_v & opnd;
        OP_OR:      new_v = old_v | opnd;
        OP_XOR:     new_v = old_v ^ opnd;
        OP_INSERT:  new_v = (old_v & ~fmask) | ((opnd << shift) & fmask);
        OP_TCLR: begin
          new_v  = old_v & ~bmask;
          result = DATA_W'(old_v[shift]);
        end
        OP_TSET: begin
          new_v  = old_v | bmask;
          result = DATA_W'(old_v[shift]);
        end
        OP_EXTRACT: result = (old_v >> shift) & wmask;
        default:    new_v = old_v;
      endcase
    end
  end

  assign wr_word = (new_v & smask) << lane_sh;

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  rmw_dec_t   dec,
  output rmw_state_e st
);

  rmw_state_e nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (req_valid) nxt = dec.bad ? ST_DONE : (dec.reads ? ST_READ : ST_WRITE);
      ST_READ:  nxt = ST_MOD;
      ST_MOD:   nxt = dec.writes ? ST_WRITE : ST_DONE;
      ST_WRITE: nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

endmodule

// File: rtl/rmw_engine.sv
module rmw_engine
  import rmw_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
  parameter logic [31:0] WIN_LIMIT = 32'h4007_FFFF,
  parameter int          INS_MAX   = 16,
  localparam int         LANES     = DATA_W / 8,
  localparam int         LB_W      = $clog2(LANES),
  localparam int         SH_W      = $clog2(DATA_W),
  localparam int         WD_W      = SH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [3:0]        req_op,
  input  logic [SH_W-1:0]   req_shift,
  input  logic [WD_W-1:0]   req_width,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              per_en,
  output logic              per_we,
  output logic [ADDR_W-1:0] per_addr,
  output logic [LANES-1:0]  per_be,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              lock
);

  rmw_dec_t          dec;
  rmw_state_e        st;
  logic [LB_W-1:0]   lane;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] smask;
  logic [DATA_W-1:0] alu_wr;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] wd_q;
  logic              err_q;

  rmw_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE),
    .WIN_LIMIT(WIN_LIMIT), .INS_MAX(INS_MAX)
  ) u_dec (
    .addr(req_addr), .size(rmw_size_e'(req_size)), .op(req_op),
    .shift(req_shift), .width(req_width),
    .dec(dec), .lane(lane), .be(be), .smask(smask)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op(req_op), .accel(dec.accel), .lane(lane), .shift(req_shift),
    .width(req_width), .smask(smask), .operand(req_wdata),
    .rdata(per_rdata), .wr_word(alu_wr), .result(alu_res)
  );

  rmw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dec(dec), .st(st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wd_q  <= '0;
      err_q <= 1'b0;
    end else if (st == ST_IDLE && req_valid) begin
      err_q <= dec.bad;
      res_q <= '0;
      wd_q  <= alu_wr;
    end else if (st == ST_MOD) begin
      res_q <= alu_res;
      wd_q  <= alu_wr;
    end
  end

  assign per_en    = (st == ST_READ) || (st == ST_WRITE);
  assign per_we    = (st == ST_WRITE);
  assign per_addr  = {req_addr[ADDR_W-1:LB_W], LB_W'(0)};
  assign per_be    = per_en ? be : '0;
  assign per_wdata = wd_q;
  assign lock      = dec.accel && ((st == ST_READ) || (st == ST_MOD) || (st == ST_WRITE));
  assign req_ready = (st == ST_DONE);
  assign rsp_rdata = (st == ST_DONE) ? res_q : '0;
  assign rsp_err   = (st == ST_DONE) && err_q;

endmodule

// File: rtl/rmw_engine_chk.sv
module rmw_engine_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_err,
  input logic             per_en,
  input logic             per_we,
  input logic [LANES-1:0] per_be,
  input logic             lock
);

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);

  a_r8_idle_bus_at_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!per_en && !lock));

  a_r9_lock_starts_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (per_en && !per_we));

  a_r9_locked_writeback_held: assert property (@(posedge clk) disable iff (!rst_n)
    (per_en && per_we && lock) |-> $past(lock));

  a_r4_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> ($countones(per_be) == 1 || $countones(per_be) == 2 ||
                $countones(per_be) == LANES));

  a_r7_reject_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && rsp_err) |-> $past(!per_en && !lock));

endmodule

bind rmw_engine rmw_engine_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_rmw_engine.sv
module tb_rmw_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [3:0]  req_op = '0;
  logic [4:0]  req_shift = '0;
  logic [5:0]  req_width = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        per_en;
  logic        per_we;
  logic [31:0] per_addr;
  logic [3:0]  per_be;
  logic [31:0] per_wdata;
  logic [31:0] per_rdata = '0;
  logic        lock;

  int checks = 0;
  int errors = 0;
  int lock_cnt = 0;

  logic [31:0] mem [4];
  logic [31:0] init_w [4];
  logic [31:0] shadow [4];

  rmw_engine dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mem[i] <= init_w[i];
    end else if (per_en) begin
      if (per_we) begin
        for (int b = 0; b < 4; b++)
          if (per_be[b]) mem[per_addr[3:2]][b*8 +: 8] <= per_wdata[b*8 +: 8];
      end else begin
        per_rdata <= mem[per_addr[3:2]];
      end
    end
  end

  always @(posedge clk) if (lock) lock_cnt <= lock_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_model(
    input  logic [31:0] a, input int sz, input int op, input int sh, input int wd,
    input  logic [31:0] wv, input logic [31:0] word,
    output bit err, output logic [31:0] res, output logic [31:0] nw, output int lk);
    int sb, lane, cap;
    bit inw, accel;
    logic [31:0] old_v, nv;
    sb   = 8 << sz;
    lane = (sz == 0) ? int'(a[1:0]) : (sz == 1) ? int'(a[1]) * 2 : 0;
    inw  = (a >= 32'h4000_0000) && (a <= 32'h4007_FFFF);
    err  = (sz == 3) || (op > 8);
    accel = inw && (op >= 2) && (op <= 8);
    res = '0; nw = word; lk = 0; old_v = '0; nv = '0;
    cap = (sb < 16) ? sb : 16;
    if (!err && accel) begin
      if (op == 5 && (wd < 1 || wd > cap || sh + wd > sb)) err = 1;
      if ((op == 6 || op == 7) && sh >= sb) err = 1;
      if (op == 8 && (wd < 1 || wd > sb || sh + wd > sb)) err = 1;
    end
    if (err) return;
    for (int i = 0; i < sb; i++) old_v[i] = word[lane*8 + i];
    if (!accel) begin
      if (op == 0 || op == 8) res = old_v;
      else for (int i = 0; i < sb; i++) nw[lane*8 + i] = wv[i];
      return;
    end
    lk = (op == 8) ? 2 : 3;
    for (int i = 0; i < sb; i++) begin
      case (op)
        2: nv[i] = old_v[i] & wv[i];
        3: nv[i] = old_v[i] | wv[i];
        4: nv[i] = old_v[i] ^ wv[i];
        5: nv[i] = (i >= sh && i < sh + wd) ? wv[i - sh] : old_v[i];
        6: nv[i] = (i == sh) ? 1'b0 : old_v[i];
        7: nv[i] = (i == sh) ? 1'b1 : old_v[i];
        default: nv[i] = old_v[i];
      endcase
    end
    if (op >= 2 && op <= 5) res = old_v;
    else if (op == 6 || op == 7) res = {31'b0, old_v[sh]};
    else for (int j = 0; j < wd; j++) res[j] = old_v[sh + j];
    for (int i = 0; i < sb; i++) nw[lane*8 + i] = nv[i];
  endfunction

  function automatic string tag_of(input logic [31:0] a, input int op, input bit err);
    bit inw;
    inw = (a >= 32'h4000_0000) && (a <= 32'h4007_FFFF);
    if (err) return "R7";
    if (!inw) return "R1";
    case (op)
      0, 1:    return "R10";
      2, 3, 4: return "R2";
      5:       return "R3";
      6, 7:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic txn(input logic [31:0] a, input int sz, input int op, input int sh,
                     input int wd, input logic [31:0] wv);
    bit e_err;
    logic [31:0] e_res, e_new;
    int e_lk, n;
    string tg;
    ref_model(a, sz, op, sh, wd, wv, shadow[a[3:2]], e_err, e_res, e_new, e_lk);
    tg = tag_of(a, op, e_err);
    @(negedge clk);
    req_addr = a; req_size = 2'(sz); req_op = 4'(op);
    req_shift = 5'(sh); req_width = 6'(wd); req_wdata = wv;
    req_valid = 1'b1;
    lock_cnt = 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!req_ready && n < 40);
    if (!req_ready) begin
      chk(1'b0, {tg, " R8 no ready"}, 32'(n), 32'd5);
    end else begin
      chk(rsp_err == e_err, {tg, " error flag"}, 32'(rsp_err), 32'(e_err));
      chk(rsp_rdata == e_res, {tg, " result"}, rsp_rdata, e_res);
      chk(mem[a[3:2]] == e_new, {tg, " R4 register image"}, mem[a[3:2]], e_new);
      chk(lock_cnt == e_lk, {tg, " R9 lock cycles"}, 32'(lock_cnt), 32'(e_lk));
    end
    shadow[a[3:2]] = e_new;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  function automatic logic [31:0] pick_addr(input int sz, input bit inwin);
    logic [31:0] base;
    int lane;
    base = inwin ? 32'h4000_1000 : 32'h2000_0000;
    lane = (sz == 0) ? int'($urandom % 4) : (sz == 1) ? int'($urandom % 2) * 2 : 0;
    return base + 32'(($urandom % 4) * 4) + 32'(lane);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      init_w[i] = $urandom;
      shadow[i] = init_w[i];
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R11 ready in reset", 32'(req_ready), 32'd0);
    chk(lock == 1'b0, "R11 lock in reset", 32'(lock), 32'd0);
    chk(per_en == 1'b0, "R11 strobe in reset", 32'(per_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int sz = 0; sz < 3; sz++) begin
      int sb;
      sb = 8 << sz;
      for (int op = 0; op < 5; op++)
        for (int k = 0; k < 8; k++) txn(pick_addr(sz, 1'b1), sz, op, 0, 0, $urandom);
      for (int sh = 0; sh < sb; sh++)
        for (int wd = 0; wd <= sb + 1 && wd < 64; wd++) begin
          txn(pick_addr(sz, 1'b1), sz, 5, sh, wd, $urandom);
          txn(pick_addr(sz, 1'b1), sz, 8, sh, wd, $urandom);
        end
      for (int sh = 0; sh <= sb && sh < 32; sh++) begin
        txn(pick_addr(sz, 1'b1), sz, 6, sh, 1, $urandom);
        txn(pick_addr(sz, 1'b1), sz, 7, sh, 1, $urandom);
      end
      for (int op = 0; op < 9; op++)
        for (int k = 0; k < 4; k++)
          txn(pick_addr(sz, 1'b0), sz, op, int'($urandom % 32), int'($urandom % 64), $urandom);
    end

    for (int op = 9; op < 16; op++) txn(pick_addr(2, 1'b1), 2, op, 0, 1, $urandom);
    txn(pick_addr(2, 1'b1), 3, 2, 0, 1, $urandom);
    txn(pick_addr(2, 1'b0), 3, 1, 0, 1, $urandom);

    txn(32'h4007_FFFC, 2, 4, 0, 0, 32'hFFFF_0000);
    txn(32'h4008_0000, 2, 4, 0, 0, 32'h1234_5678);
    txn(32'h3FFF_FFFF, 0, 7, 3, 1, 32'h0000_00A5);
    txn(32'h4000_0000, 0, 7, 7, 1, 32'h0);
    txn(32'h4000_0003, 0, 6, 0, 1, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule